// File: doc/BRIEF.md
# One-Time-Programmable Security Register Bank

This block models the one-time-programmable security area of a flash device as seen from its host bus. It holds one 128-bit register split into a factory identifier half and a user half, sixteen further 128-bit user registers, and two lock words. Every storage and lock cell behaves as a fuse. An unwritten bit reads 1. Programming can only turn 1s into 0s, so the new value is the old value AND the written data. A lock bit is in force once it reads 0.

The host changes contents with a two-write sequence. The first write carries an opcode at a target address, and the second write carries 16 bits of data to the same address. Errors are kept as sticky status bits until a clear-status opcode is written. After every data write the block reports busy for a fixed number of cycles and ignores writes during that time. Reads of storage and lock words are available on every cycle.

Top module: `otp_prot_ctrl`

## Requirements
- R1: After reset, `status` is 0x80. Every storage word reads 0xFFFF, except identifier word i (address 0x81+i, i = 0..3), which reads bits 16i+15:16i of the `FACTORY_ID` parameter. Lock word 0 reads 0xFFFE and lock word 1 reads 0xFFFF.
- R2: A read is requested by `bus_re` high with `bus_addr`, and `bus_rdata` holds the addressed word from the next cycle. A program sequence is opcode 0x00C0 written to a storage address, followed by a data write to the same address. It changes that word to old AND data.
- R3: Address map. 0x80 is lock word 0. 0x81–0x88 is register 0, with the identifier half at 0x81–0x84 and the user half at 0x85–0x88. 0x89 is lock word 1. Upper register k (k = 0..15) occupies 0x8A+8k to 0x8A+8k+7, which ends at 0x109. Reads at any other address return 0xFFFF.
- R4: Opcode 0x00C0 at an address that is not a storage word sets status bit 4, starts no sequence and changes nothing else.
- R5: A data write aimed at a locked word leaves the word unchanged and sets both status bit 4 and status bit 1. Bit 1 is never set without bit 4.
- R6: A lock sequence is opcode 0x00C8 at 0x80 or 0x89, followed by a data write to the same address, and ANDs the data into that lock word. Only bits 1:0 of lock word 0 exist, and its bits 15:2 always read 1. Opcode 0x00C8 at any other address sets status bit 4.
- R7: The locks map as follows. Lock word 0 bit 0 protects 0x81–0x84 and is in force from reset. Lock word 0 bit 1 protects 0x85–0x88. Lock word 1 bit k protects upper register k only.
- R8: A lock bit that reads 0 never returns to 1.
- R9: If the data write of a sequence uses a different address from its opcode write, status bit 4 is set and no word changes.
- R10: A first write whose value is not one of the three opcodes is ignored. No state or status changes.
- R11: Opcode 0x0050 clears status bits 4 and 1. Apart from that, both bits keep their value. Status bits 6:5, 3:2 and 0 are always 0.
- R12: After each data write, status bit 7 reads 0 for exactly `BUSY_CYCLES` (default 4) cycles. Writes made during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per bus write |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 9 | Word address shared by reads and writes |
| bus_wdata | input | 16 | Write data or opcode |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_re` |
| status | output | 8 | Bit 7 ready, bit 4 program error, bit 1 lock error |

## Verification
The assertions assume that `bus_we` is a single-cycle pulse that carries one opcode or one data value. They also assume that `bus_wdata` equal to 0x0050 is the only way the error bits may fall. The stimulus drives each write for exactly one clock and waits for the ready bit before it starts the next sequence, except in the deliberate busy-window case. When an opcode is rejected by the address check, the bench does not send a data write, because that value would be decoded as a new opcode. Random stimulus mixes program, lock, clear, illegal-opcode and read operations at in-range and out-of-range addresses. Directed cases cover the first and last storage words, the address gaps, lock removal attempts and address mismatch.

// File: rtl/otp_pkg.sv
// Package: shared types and constants of the security register bank.
// Assumes 16-bit bus data; opcodes are full 16-bit compare values.
package otp_pkg;

    localparam logic [15:0] OPC_PROG = 16'h00C0;
    localparam logic [15:0] OPC_LOCK = 16'h00C8;
    localparam logic [15:0] OPC_CLR  = 16'h0050;

    localparam int ST_READY = 7;
    localparam int ST_PERR  = 4;
    localparam int ST_LERR  = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PROG = 2'd1,
        SEQ_LOCK = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic is_lock0;
        logic is_lock1;
        logic is_word;
        logic locked;
    } addr_info_t;

endpackage

// File: rtl/otp_addr_map.sv
// Address decoder: classifies a bus address as lock word 0, lock word 1,
// storage word or nothing. Returns the flat storage index and whether the
// word's protecting lock bit is in force (reads 0).
// Assumes WPR and NUM_UPPER are powers of two, and that the whole map
// fits in ADDR_W bits.
module otp_addr_map
    import otp_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int BASE      = 128,
    parameter int WPR       = 8,
    parameter int NUM_UPPER = 16,
    parameter int IDX_W     = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [1:0]           lock0_bits,
    input  logic [NUM_UPPER-1:0] lock1_bits,
    output addr_info_t           info,
    output logic [IDX_W-1:0]     word_idx
);
    localparam int LOCK0_A  = BASE;
    localparam int R0_FIRST = BASE + 1;
    localparam int R0_LAST  = BASE + WPR;
    localparam int LOCK1_A  = BASE + WPR + 1;
    localparam int UP_FIRST = LOCK1_A + 1;
    localparam int UP_LAST  = UP_FIRST + NUM_UPPER * WPR - 1;
    localparam int WSEL_W   = $clog2(WPR);
    localparam int RSEL_W   = (NUM_UPPER > 1) ? $clog2(NUM_UPPER) : 1;

    logic              in_r0;
    logic              in_up;
    logic [ADDR_W-1:0] rel_r0;
    logic [ADDR_W-1:0] rel_up;
    logic [RSEL_W-1:0] up_sel;

    // Range compares and offsets relative to each region
    always_comb begin
        in_r0  = (addr >= ADDR_W'(R0_FIRST)) && (addr <= ADDR_W'(R0_LAST));
        in_up  = (addr >= ADDR_W'(UP_FIRST)) && (addr <= ADDR_W'(UP_LAST));
        rel_r0 = addr - ADDR_W'(R0_FIRST);
        rel_up = addr - ADDR_W'(UP_FIRST);
        up_sel = rel_up[WSEL_W +: RSEL_W];
    end

    // Classification, flat index and lock lookup
    always_comb begin
        info.is_lock0 = (addr == ADDR_W'(LOCK0_A));
        info.is_lock1 = (addr == ADDR_W'(LOCK1_A));
        info.is_word  = in_r0 || in_up;
        info.locked   = 1'b0;
        word_idx      = '0;
        if (in_r0) begin
            word_idx = IDX_W'(rel_r0);
            if (rel_r0 < ADDR_W'(WPR / 2)) begin
                info.locked = ~lock0_bits[0];
            end else begin
                info.locked = ~lock0_bits[1];
            end
        end else if (in_up) begin
            word_idx    = IDX_W'(rel_up) + IDX_W'(WPR);
            info.locked = ~lock1_bits[up_sel];
        end
    end

endmodule

// File: rtl/otp_cmd_seq.sv
// Command sequencer: decodes opcode writes, arms a program or lock
// sequence, validates the data write (same address, target not locked),
// raises write strobes, keeps the sticky error flags and the busy window.
// Assumes bus_we is a one-cycle pulse per bus write.
module otp_cmd_seq
    import otp_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 16,
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  addr_info_t        info,
    output logic              prog_en,
    output logic              lock0_en,
    output logic              lock1_en,
    output logic              busy,
    output logic              armed,
    output logic              perr,
    output logic              lerr
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    seq_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              take;
    logic              same_addr;

    // Accept condition and address match against the armed target
    always_comb begin
        busy      = (cnt_q != '0);
        armed     = (state_q != SEQ_IDLE);
        take      = bus_we && !busy;
        same_addr = (bus_addr == addr_q);
    end

    // Storage and lock write strobes for a valid data phase
    always_comb begin
        prog_en  = take && (state_q == SEQ_PROG) && same_addr && !info.locked;
        lock0_en = take && (state_q == SEQ_LOCK) && same_addr && info.is_lock0;
        lock1_en = take && (state_q == SEQ_LOCK) && same_addr && info.is_lock1;
    end

    // Sequence state, armed address, busy counter and error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            cnt_q   <= '0;
            perr    <= 1'b0;
            lerr    <= 1'b0;
        end else begin
            if (busy) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (take) begin
                unique case (state_q)
                    SEQ_IDLE: begin
                        if (bus_wdata == DATA_W'(OPC_PROG)) begin
                            if (info.is_word) begin
                                state_q <= SEQ_PROG;
                                addr_q  <= bus_addr;
                            end else begin
                                perr <= 1'b1;
                            end
                        end else if (bus_wdata == DATA_W'(OPC_LOCK)) begin
                            if (info.is_lock0 || info.is_lock1) begin
                                state_q <= SEQ_LOCK;
                                addr_q  <= bus_addr;
                            end else begin
                                perr <= 1'b1;
                            end
                        end else if (bus_wdata == DATA_W'(OPC_CLR)) begin
                            perr <= 1'b0;
                            lerr <= 1'b0;
                        end
                    end
                    SEQ_PROG: begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= CNT_W'(BUSY_CYCLES);
                        if (!same_addr) begin
                            perr <= 1'b1;
                        end else if (info.locked) begin
                            perr <= 1'b1;
                            lerr <= 1'b1;
                        end
                    end
                    SEQ_LOCK: begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= CNT_W'(BUSY_CYCLES);
                        if (!same_addr) begin
                            perr <= 1'b1;
                        end
                    end
                    default: state_q <= SEQ_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/otp_store.sv
// Fuse storage: flat word array and both lock words, all AND-only on write.
// Holds the factory identifier from reset, and lock word 0 bit 0 reset to 0.
// Registered read port selected by the shared address decode.
// Assumes NUM_UPPER <= DATA_W.
module otp_store
    import otp_pkg::*;
#(
    parameter int                          DATA_W     = 16,
    parameter int                          TOTAL      = 136,
    parameter int                          IDX_W      = 8,
    parameter int                          ID_WORDS   = 4,
    parameter int                          NUM_UPPER  = 16,
    parameter logic [ID_WORDS*DATA_W-1:0]  FACTORY_ID = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prog_en,
    input  logic                 lock0_en,
    input  logic                 lock1_en,
    input  logic [IDX_W-1:0]     word_idx,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 rd_en,
    input  addr_info_t           info,
    output logic [1:0]           lock0_bits,
    output logic [NUM_UPPER-1:0] lock1_bits,
    output logic [DATA_W-1:0]    rdata
);
    localparam int PAD_W = DATA_W - NUM_UPPER;

    logic [DATA_W-1:0] mem [TOTAL];
    logic [DATA_W-1:0] lock0_word;
    logic [DATA_W-1:0] lock1_word;

    // Storage words: identifier loaded at reset, AND-only programming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) begin
                if (i < ID_WORDS) begin
                    mem[i] <= FACTORY_ID[i*DATA_W +: DATA_W];
                end else begin
                    mem[i] <= '1;
                end
            end
        end else if (prog_en) begin
            mem[word_idx] <= mem[word_idx] & wdata;
        end
    end

    // Lock words: factory bit preset, bits can only fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock0_bits <= 2'b10;
            lock1_bits <= '1;
        end else begin
            if (lock0_en) begin
                lock0_bits <= lock0_bits & wdata[1:0];
            end
            if (lock1_en) begin
                lock1_bits <= lock1_bits & wdata[NUM_UPPER-1:0];
            end
        end
    end

    // Read views of the lock words, unused bits reading as unprogrammed
    assign lock0_word = {{(DATA_W-2){1'b1}}, lock0_bits};
    generate
        if (PAD_W > 0) begin : g_lock1_pad
            assign lock1_word = {{PAD_W{1'b1}}, lock1_bits};
        end else begin : g_lock1_full
            assign lock1_word = lock1_bits;
        end
    endgenerate

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '1;
        end else if (rd_en) begin
            if (info.is_lock0) begin
                rdata <= lock0_word;
            end else if (info.is_lock1) begin
                rdata <= lock1_word;
            end else if (info.is_word) begin
                rdata <= mem[word_idx];
            end else begin
                rdata <= '1;
            end
        end
    end

endmodule

// File: rtl/otp_prot_ctrl.sv
// Top: fuse-style security register bank with lock control.
// One shared address decode feeds the sequencer and the storage read port.
// Assumes a single host issuing one-cycle write and read strobes.
module otp_prot_ctrl
    import otp_pkg::*;
#(
    parameter int                 ADDR_W      = 9,
    parameter int                 DATA_W      = 16,
    parameter int                 BASE        = 128,
    parameter int                 WPR         = 8,
    parameter int                 NUM_UPPER   = 16,
    parameter int                 BUSY_CYCLES = 4,
    parameter logic [63:0]        FACTORY_ID  = 64'hA5C3_1E0F_7B29_D468
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [8:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [7:0]        status
);
    localparam int TOTAL    = WPR * (NUM_UPPER + 1);
    localparam int IDX_W    = $clog2(TOTAL);
    localparam int ID_WORDS = WPR / 2;

    addr_info_t           info;
    logic [IDX_W-1:0]     word_idx;
    logic [1:0]           lock0_bits;
    logic [NUM_UPPER-1:0] lock1_bits;
    logic                 prog_en;
    logic                 lock0_en;
    logic                 lock1_en;
    logic                 busy;
    logic                 armed;
    logic                 perr;
    logic                 lerr;

    otp_addr_map #(
        .ADDR_W(ADDR_W), .BASE(BASE), .WPR(WPR),
        .NUM_UPPER(NUM_UPPER), .IDX_W(IDX_W)
    ) u_map (
        .addr       (bus_addr),
        .lock0_bits (lock0_bits),
        .lock1_bits (lock1_bits),
        .info       (info),
        .word_idx   (word_idx)
    );

    otp_cmd_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .info      (info),
        .prog_en   (prog_en),
        .lock0_en  (lock0_en),
        .lock1_en  (lock1_en),
        .busy      (busy),
        .armed     (armed),
        .perr      (perr),
        .lerr      (lerr)
    );

    otp_store #(
        .DATA_W(DATA_W), .TOTAL(TOTAL), .IDX_W(IDX_W), .ID_WORDS(ID_WORDS),
        .NUM_UPPER(NUM_UPPER), .FACTORY_ID(FACTORY_ID[ID_WORDS*DATA_W-1:0])
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_en    (prog_en),
        .lock0_en   (lock0_en),
        .lock1_en   (lock1_en),
        .word_idx   (word_idx),
        .wdata      (bus_wdata),
        .rd_en      (bus_re),
        .info       (info),
        .lock0_bits (lock0_bits),
        .lock1_bits (lock1_bits),
        .rdata      (bus_rdata)
    );

    // Status byte assembly: ready, program error, lock error
    always_comb begin
        status           = '0;
        status[ST_READY] = ~busy;
        status[ST_PERR]  = perr;
        status[ST_LERR]  = lerr;
    end

endmodule

// File: rtl/otp_prot_ctrl_chk.sv
// Checker: temporal properties of the security register bank, bound into
// the top. Assumes one-cycle write strobes on the host bus.
module otp_prot_ctrl_chk
    import otp_pkg::*;
#(
    parameter int NUM_UPPER = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_we,
    input logic [15:0]          bus_wdata,
    input logic [7:0]           status,
    input logic                 busy,
    input logic                 armed,
    input logic [1:0]           lock0_bits,
    input logic [NUM_UPPER-1:0] lock1_bits
);
    logic past_ok;

    // Marks cycles whose previous cycle was already out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_lockerr_with_progerr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_LERR] |-> status[ST_PERR]);

    assert_lock_bits_never_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (((~$past(lock0_bits)) & lock0_bits) == '0 &&
                     ((~$past(lock1_bits)) & lock1_bits) == '0));

    assert_factory_lock_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (lock0_bits[0] == 1'b0));

    assert_perr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(status[ST_PERR]) &&
         !($past(bus_we) && $past(bus_wdata) == OPC_CLR)) |-> status[ST_PERR]);

    assert_status_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6:5] == 2'b00) && (status[3:2] == 2'b00) && (status[0] == 1'b0));

    assert_busy_after_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && armed && !busy) |=> !status[ST_READY]);

    assert_busy_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && busy) |=> !armed);

endmodule

bind otp_prot_ctrl otp_prot_ctrl_chk #(.NUM_UPPER(NUM_UPPER)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .status     (status),
    .busy       (busy),
    .armed      (armed),
    .lock0_bits (lock0_bits),
    .lock1_bits (lock1_bits)
);

// File: tb/otp_prot_ctrl_tb.sv
module otp_prot_ctrl_tb;
    localparam logic [63:0] FID   = 64'hA5C3_1E0F_7B29_D468;
    localparam int          BUSYC = 4;
    localparam logic [15:0] C_PROG = 16'h00C0;
    localparam logic [15:0] C_LOCK = 16'h00C8;
    localparam logic [15:0] C_CLR  = 16'h0050;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  status;

    int checks = 0;
    int fails  = 0;

    // Bench model of the requirements
    logic [15:0] m_mem [136];
    logic [1:0]  m_l0;
    logic [15:0] m_l1;
    logic        m_perr;
    logic        m_lerr;

    always #4 clk = ~clk;

    otp_prot_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .status(status)
    );

    // R3: address classes (0 none, 1 lock word 0, 2 lock word 1, 3 storage)
    function automatic int kind_of(input logic [8:0] a);
        if (a == 9'h080) return 1;
        if (a == 9'h089) return 2;
        if (a >= 9'h081 && a <= 9'h088) return 3;
        if (a >= 9'h08A && a <= 9'h109) return 3;
        return 0;
    endfunction

    function automatic int idx_of(input logic [8:0] a);
        if (a <= 9'h088) return int'(a) - 'h81;
        return int'(a) - 'h8A + 8;
    endfunction

    // R7: lock in force for a storage address
    function automatic bit locked_of(input logic [8:0] a);
        int i = idx_of(a);
        if (i < 4) return !m_l0[0];
        if (i < 8) return !m_l0[1];
        return !m_l1[(i - 8) / 8];
    endfunction

    function automatic logic [15:0] exp_read(input logic [8:0] a);
        case (kind_of(a))
            1: return {14'h3FFF, m_l0};
            2: return m_l1;
            3: return m_mem[idx_of(a)];
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {1'b1, 2'b00, m_perr, 2'b00, m_lerr, 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wait_ready();
        while (!status[7]) @(negedge clk);
    endtask

    task automatic check_read(input string req, input logic [8:0] a);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        check(req, {16'h0, bus_rdata}, {16'h0, exp_read(a)});
    endtask

    task automatic check_status(input string req);
        wait_ready();
        check(req, {24'h0, status}, {24'h0, exp_status()});
    endtask

    // R2/R4/R5/R9: full program sequence with model update
    task automatic do_prog(input logic [8:0] a, input logic [15:0] d);
        wait_ready();
        bus_write(a, C_PROG);
        if (kind_of(a) != 3) begin
            m_perr = 1'b1;
        end else begin
            bus_write(a, d);
            if (locked_of(a)) begin
                m_perr = 1'b1; m_lerr = 1'b1;
            end else begin
                m_mem[idx_of(a)] &= d;
            end
        end
        wait_ready();
    endtask

    // R6: lock sequence with model update
    task automatic do_lock(input logic [8:0] a, input logic [15:0] d);
        wait_ready();
        bus_write(a, C_LOCK);
        if (kind_of(a) == 1) begin
            bus_write(a, d); m_l0 &= d[1:0];
        end else if (kind_of(a) == 2) begin
            bus_write(a, d); m_l1 &= d;
        end else begin
            m_perr = 1'b1;
        end
        wait_ready();
    endtask

    task automatic do_clear();
        wait_ready();
        bus_write(9'h000, C_CLR);
        m_perr = 1'b0; m_lerr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int ncyc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 136; i++) m_mem[i] = (i < 4) ? FID[i*16 +: 16] : 16'hFFFF;
        m_l0 = 2'b10; m_l1 = 16'hFFFF; m_perr = 1'b0; m_lerr = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 status", {24'h0, status}, 32'h80);
        for (int i = 0; i < 4; i++) check_read("R1 id word", 9'h081 + 9'(i));
        check_read("R1 lock0", 9'h080);
        check_read("R1 lock1", 9'h089);
        check_read("R1 user word", 9'h085);

        // R2: program and AND behaviour
        do_prog(9'h085, 16'h1234);
        check_read("R2 first program", 9'h085);
        do_prog(9'h085, 16'hFF00);
        check_read("R2 AND program", 9'h085);
        check("R2 value", {16'h0, m_mem[4]}, 32'h1200);

        // R5/R7: identifier half locked from reset
        do_prog(9'h081, 16'h0000);
        check_status("R5 lock error status");
        check_read("R7 id unchanged", 9'h081);

        // R11: clear
        do_clear();
        check_status("R11 clear");

        // R4: out of range targets
        do_prog(9'h120, 16'h0000);
        check_status("R4 out of range");
        do_clear();
        do_prog(9'h089, 16'h0000);
        check_status("R4 lock1 address as word");
        do_clear();

        // R3: last word and first beyond it
        do_prog(9'h109, 16'h5A5A);
        check_read("R3 last word", 9'h109);
        check_status("R3 last word status");
        do_prog(9'h10A, 16'h0000);
        check_status("R3 beyond map");
        check_read("R3 unmapped read", 9'h10A);
        do_clear();

        // R7/R8: lock upper register 3, then attempt to release it
        do_lock(9'h089, 16'hFFF7);
        check_read("R6 lock1 value", 9'h089);
        do_prog(9'h0A2, 16'h0000);
        check_status("R7 upper reg lock");
        check_read("R7 locked word", 9'h0A2);
        do_clear();
        do_prog(9'h0AA, 16'h00FF);
        check_read("R7 neighbour free", 9'h0AA);
        do_lock(9'h089, 16'hFFFF);
        check_read("R8 no release", 9'h089);

        // R6: lock command at a non-lock address
        do_lock(9'h090, 16'h0000);
        check_status("R6 bad lock address");
        do_clear();

        // R10: non-opcode first write
        wait_ready();
        bus_write(9'h090, 16'h00FF);
        bus_write(9'h090, 16'h0000);
        check_status("R10 ignored status");
        check_read("R10 word unchanged", 9'h090);

        // R9: address mismatch
        wait_ready();
        bus_write(9'h090, C_PROG);
        bus_write(9'h091, 16'h0000);
        m_perr = 1'b1;
        check_status("R9 mismatch status");
        check_read("R9 first unchanged", 9'h090);
        check_read("R9 second unchanged", 9'h091);
        do_clear();

        // R12: busy length and ignored writes
        wait_ready();
        bus_write(9'h095, C_PROG);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 9'h095; bus_wdata = 16'hF0F0;
        @(negedge clk);
        bus_we = 1'b0;
        m_mem[idx_of(9'h095)] &= 16'hF0F0;
        ncyc = 0;
        while (!status[7]) begin ncyc++; @(negedge clk); end
        check("R12 busy cycles", ncyc, BUSYC);
        bus_write(9'h096, C_PROG);
        bus_write(9'h096, 16'h0000);
        ncyc = 0;
        while (!status[7]) begin ncyc++; @(negedge clk); end
        bus_write(9'h097, C_PROG);
        bus_write(9'h097, 16'h0000);
        @(negedge clk);
        check("R12 busy after second", {31'h0, status[7]}, 32'h0);
        bus_write(9'h097, C_PROG);
        bus_write(9'h097, 16'h0000);
        m_mem[idx_of(9'h096)] = 16'h0000;
        m_mem[idx_of(9'h097)] = 16'h0000;
        wait_ready();
        check_read("R12 busy write ignored", 9'h098);
        check_read("R12 word programmed", 9'h097);

        // R6/R7: lock word 0 with all bits cleared; user half becomes locked
        do_lock(9'h080, 16'h0000);
        check_read("R6 lock0 unused bits", 9'h080);
        do_prog(9'h086, 16'h0000);
        check_status("R7 user half lock");
        do_clear();

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 99);
            logic [8:0] a;
            if (op < 55) begin
                if ($urandom_range(0, 9) == 0) a = 9'($urandom_range(0, 511));
                else begin
                    int i = $urandom_range(0, 135);
                    a = (i < 8) ? 9'(8'h81 + i) : 9'('h8A + i - 8);
                end
                do_prog(a, 16'($urandom));
                check_status("R2 random program status");
                if (kind_of(a) == 3) check_read("R2 random program read", a);
            end else if (op < 58) begin
                do_lock(9'h089, ~(16'h1 << $urandom_range(0, 15)));
                check_read("R8 random lock", 9'h089);
            end else if (op < 68) begin
                do_clear();
                check_status("R11 random clear");
            end else if (op < 75) begin
                logic [15:0] v = 16'($urandom);
                if (v == C_PROG || v == C_LOCK || v == C_CLR) v = 16'h1111;
                wait_ready();
                bus_write(9'($urandom_range(0, 511)), v);
                check_status("R10 random junk");
            end else begin
                check_read("R3 random read", 9'($urandom_range(0, 511)));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule